// File: doc/BRIEF.md
# Conditional Trap Evaluator

This block decides, for one fixed-point trap instruction per cycle, whether that instruction raises a program exception. It receives two operands and a 5-bit condition mask. A size select picks a 32-bit (word) or 64-bit (doubleword) comparison. A form select picks a register second operand or a sign-extended 16-bit immediate. A machine-mode input says whether 64-bit operation is enabled. Five comparison results, each enabled by one bit of the mask, are ORed together to form the trap condition. The all-zeros mask never traps and the all-ones mask always traps.

The block also flags a doubleword request made outside 64-bit mode as an illegal instruction. In that case it requests no trap. Both outputs are registered and pulse for one cycle, one cycle after the accepted instruction. The block takes a new instruction on every cycle, so it applies no back-pressure and has no ready output.

Top module: `trap_eval`

## Requirements
- R1: After reset, and while reset is held, `trap_req` and `illegal_op` are low.
- R2: A mask of 0 never requests a trap, whatever the operands.
- R3: A mask of 31 on a legal instruction always requests a trap, whatever the operands.
- R4: Each mask bit enables one condition. Bit 4 enables signed A<B, bit 3 signed A>B, bit 2 A==B, bit 1 unsigned A<B and bit 0 unsigned A>B. A trap is requested when any enabled condition holds.
- R5: With `in_dword`=0, only bits 31:0 of each operand are compared, as signed or unsigned 32-bit values. The upper bits have no effect on `trap_req`.
- R6: With `in_use_imm`=1, the second operand is `in_imm` sign-extended to the operand width, and `in_b` is ignored.
- R7: With `in_dword`=1 and `mode64`=0, `illegal_op` pulses and `trap_req` stays low. `trap_req` and `illegal_op` are never high together.
- R8: Each output is high for exactly the one cycle following a cycle with `in_valid`=1 whose result asserts it. Both outputs are low in any cycle after a cycle with `in_valid`=0.
- R9: With `in_dword`=1 and `mode64`=1, all 64 bits of each operand are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_to | input | 5 | Condition mask |
| in_dword | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| in_use_imm | input | 1 | 1 = immediate second operand |
| mode64 | input | 1 | 64-bit mode enabled |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Register second operand |
| in_imm | input | 16 | Signed immediate |
| trap_req | output | 1 | Trap request pulse |
| illegal_op | output | 1 | Illegal doubleword request pulse |

## Verification
The illegal-instruction check and the trap decision act on the same instruction in the same cycle. The bench provokes this by presenting every doubleword case, including masks 0 and 31, with `mode64` both low and high. The bench's rule is that the illegal flag wins: for such an instruction it expects `illegal_op` high and `trap_req` low. The full mask sweep over signed and unsigned edge operands, in both register and immediate forms, shows that no legal case is suppressed.

// File: rtl/trap_eval_pkg.sv
package trap_eval_pkg;
  localparam int unsigned MASK_W = 5;
  localparam logic [MASK_W-1:0] MASK_NEVER  = '0;
  localparam logic [MASK_W-1:0] MASK_ALWAYS = '1;

  // Field order matches the condition-mask bit order (bit 4 first).
  typedef struct packed {
    logic lt_s;
    logic gt_s;
    logic eq;
    logic lt_u;
    logic gt_u;
  } cmp_flags_t;
endpackage

// File: rtl/trap_operand_prep.sv
module trap_operand_prep #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [IMM_W-1:0] imm,
  input  logic             dword,
  input  logic             use_imm,
  output logic [XLEN:0]    sa,
  output logic [XLEN:0]    sb,
  output logic [XLEN:0]    ua,
  output logic [XLEN:0]    ub
);
  localparam int unsigned EXT_W  = XLEN + 1 - WORD_W;
  localparam int unsigned IPAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] b_pick;

  always_comb begin
    b_pick = use_imm ? {{IPAD_W{imm[IMM_W-1]}}, imm} : b;
    if (dword) begin
      sa = {a[XLEN-1], a};
      sb = {b_pick[XLEN-1], b_pick};
      ua = {1'b0, a};
      ub = {1'b0, b_pick};
    end else begin
      sa = {{EXT_W{a[WORD_W-1]}}, a[WORD_W-1:0]};
      sb = {{EXT_W{b_pick[WORD_W-1]}}, b_pick[WORD_W-1:0]};
      ua = {{EXT_W{1'b0}}, a[WORD_W-1:0]};
      ub = {{EXT_W{1'b0}}, b_pick[WORD_W-1:0]};
    end
  end
endmodule

// File: rtl/trap_compare.sv
module trap_compare
  import trap_eval_pkg::*;
#(
  parameter int unsigned W = 65
) (
  input  logic [W-1:0] sa,
  input  logic [W-1:0] sb,
  input  logic [W-1:0] ua,
  input  logic [W-1:0] ub,
  output cmp_flags_t   flags
);
  always_comb begin
    flags.lt_s = $signed(sa) < $signed(sb);
    flags.gt_s = $signed(sa) > $signed(sb);
    flags.eq   = ua == ub;
    flags.lt_u = ua < ub;
    flags.gt_u = ua > ub;
  end
endmodule

// File: rtl/trap_decide.sv
module trap_decide
  import trap_eval_pkg::*;
(
  input  logic [MASK_W-1:0] to,
  input  cmp_flags_t        flags,
  output logic              fire
);
  logic any_hit;

  always_comb begin
    any_hit = |(to & flags);
    if (to == MASK_NEVER)       fire = 1'b0;
    else if (to == MASK_ALWAYS) fire = 1'b1;
    else                        fire = any_hit;
  end
endmodule

// File: rtl/trap_eval.sv
module trap_eval
  import trap_eval_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MASK_W-1:0] in_to,
  input  logic              in_dword,
  input  logic              in_use_imm,
  input  logic              mode64,
  input  logic [XLEN-1:0]   in_a,
  input  logic [XLEN-1:0]   in_b,
  input  logic [IMM_W-1:0]  in_imm,
  output logic              trap_req,
  output logic              illegal_op
);
  localparam int unsigned CW = XLEN + 1;

  logic [CW-1:0] sa, sb, ua, ub;
  cmp_flags_t    flags;
  logic          fire;
  logic          bad_size;

  trap_operand_prep #(.XLEN(XLEN), .WORD_W(WORD_W), .IMM_W(IMM_W)) u_prep (
    .a(in_a), .b(in_b), .imm(in_imm), .dword(in_dword), .use_imm(in_use_imm),
    .sa(sa), .sb(sb), .ua(ua), .ub(ub)
  );

  trap_compare #(.W(CW)) u_cmp (
    .sa(sa), .sb(sb), .ua(ua), .ub(ub), .flags(flags)
  );

  trap_decide u_dec (
    .to(in_to), .flags(flags), .fire(fire)
  );

  assign bad_size = in_dword & ~mode64;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      trap_req   <= in_valid & ~bad_size & fire;
      illegal_op <= in_valid & bad_size;
    end
  end
endmodule

// File: rtl/trap_eval_chk.sv
module trap_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [4:0] in_to,
  input logic       in_dword,
  input logic       mode64,
  input logic       trap_req,
  input logic       illegal_op
);
  // R7
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_req && illegal_op));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!trap_req && !illegal_op));

  // R2
  never_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_to == 5'd0) |=> !trap_req);

  // R3
  always_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_to == 5'd31 && !(in_dword && !mode64)) |=> trap_req);

  // R7
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dword && !mode64) |=> (illegal_op && !trap_req));
endmodule

bind trap_eval trap_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_to(in_to),
  .in_dword(in_dword), .mode64(mode64), .trap_req(trap_req),
  .illegal_op(illegal_op)
);

// File: tb/tb_trap_eval.sv
module tb_trap_eval;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  in_to;
  logic        in_dword;
  logic        in_use_imm;
  logic        mode64;
  logic [63:0] in_a;
  logic [63:0] in_b;
  logic [15:0] in_imm;
  logic        trap_req;
  logic        illegal_op;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  trap_eval dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_to(in_to),
    .in_dword(in_dword), .in_use_imm(in_use_imm), .mode64(mode64),
    .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .trap_req(trap_req), .illegal_op(illegal_op)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic logic model_trap(input logic [4:0] to, input logic [63:0] a,
                                      input logic [63:0] b, input logic dw);
    longint          sx, sy;
    longint unsigned ux, uy;
    if (dw) begin
      sx = $signed(a); sy = $signed(b); ux = a; uy = b;
    end else begin
      sx = longint'($signed(a[31:0])); sy = longint'($signed(b[31:0]));
      ux = {32'd0, a[31:0]}; uy = {32'd0, b[31:0]};
    end
    if (to == 5'd0) return 1'b0;
    if (to == 5'd31) return 1'b1;
    return (to[4] && sx < sy) || (to[3] && sx > sy) || (to[2] && ux == uy) ||
           (to[1] && ux < uy) || (to[0] && ux > uy);
  endfunction

  function automatic logic [63:0] pick_a(input int i);
    case (i)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'd2;
      3: return 64'hFFFF_FFFF_FFFF_FFFF;
      4: return 64'h1234_5678_0000_0005;
      5: return 64'h0000_0000_8000_0000;
      6: return 64'h7FFF_FFFF_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_0000_0001;
    endcase
  endfunction

  function automatic logic [63:0] pick_b(input int i);
    case (i)
      0: return 64'd0;
      1: return 64'd2;
      2: return 64'd1;
      3: return 64'd1;
      4: return 64'h0000_0000_0000_0005;
      5: return 64'd0;
      6: return 64'h8000_0000_0000_0000;
      default: return 64'd1;
    endcase
  endfunction

  function automatic logic [15:0] pick_imm(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h0001;
      4: return 16'h0005;
      5: return 16'h7FFF;
      6: return 16'hFFFE;
      default: return 16'h0002;
    endcase
  endfunction

  task automatic run_op(input logic [4:0] to, input int i, input logic dw,
                        input logic ui, input logic m64);
    logic [63:0] bop;
    logic        e_ill, e_trap;
    string       tag;
    in_valid = 1'b1; in_to = to; in_dword = dw; in_use_imm = ui; mode64 = m64;
    in_a = pick_a(i); in_b = pick_b(i); in_imm = pick_imm(i);
    bop = ui ? {{48{in_imm[15]}}, in_imm} : in_b;
    e_ill = dw & ~m64;
    e_trap = ~e_ill & model_trap(to, in_a, bop, dw);
    if (e_ill)            tag = "R7";
    else if (to == 5'd0)  tag = "R2";
    else if (to == 5'd31) tag = "R3";
    else if (ui)          tag = "R6";
    else if (dw)          tag = "R9";
    else if (i == 4 || i == 7) tag = "R5";
    else                  tag = "R4";
    @(negedge clk);
    in_valid = 1'b0;
    check(trap_req, e_trap, tag);
    check(illegal_op, e_ill, "R7/R8");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; in_to = 5'd31; in_dword = 1'b1;
    in_use_imm = 1'b0; mode64 = 1'b0; in_a = '0; in_b = '0; in_imm = '0;
    repeat (3) @(negedge clk);
    check(trap_req, 1'b0, "R1");
    check(illegal_op, 1'b0, "R1");
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(trap_req, 1'b0, "R1");
    // Idle input with an always-trap mask: no pulse (R8)
    in_to = 5'd31; in_dword = 1'b0; mode64 = 1'b1;
    @(negedge clk);
    check(trap_req, 1'b0, "R8");
    check(illegal_op, 1'b0, "R8");
    for (int to = 0; to < 32; to++)
      for (int i = 0; i < 8; i++)
        for (int f = 0; f < 8; f++)
          run_op(5'(to), i, f[0], f[1], f[2]);
    // Pulse width: one op then idle must drop (R8)
    run_op(5'd31, 0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check(trap_req, 1'b0, "R8");
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule